// File: doc/BRIEF.md
# SPI Command Decoder and Configuration Register File

This block is an SPI target (mode 0: the host samples MISO on the rising clock edge, and the block changes MISO on the falling edge). It receives byte-wide commands from a host microcontroller and keeps the configuration state of a cartridge-emulation device. The block samples the SPI pins through synchronisers in its own clock domain. It assembles the serial bits into bytes and decodes the first byte of each frame as an opcode. The opcode's upper nibble picks the command class and its lower nibble carries inline fields: a memory target, a post-increment flag or a mapper number.

Parameter bytes follow the opcode, most significant byte first. With them the host loads:
- the access addresses for three memory targets;
- two 24-bit address masks;
- a mapper mode;
- a feature-enable byte;
- an 8-bit status register, changed through a pair of set and clear masks.

The host can also stream writes into one of the targets and stream reads out of main RAM, each with optional post-increment. On readback opcodes the block returns a test token, a 16-bit status word or an echo of each byte, one byte slot later. The memories themselves lie outside the block and are reached through a simple request port with a one-cycle read latency.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Bytes are received most significant bit first while `spi_cs_n` is low. Raising `spi_cs_n` clears the byte position and the opcode, so a command whose last parameter byte was not received changes nothing.
- R2: Opcode 0x00 followed by three bytes loads the 24-bit RAM address. Opcodes 0x01 and 0x02 followed by two bytes load the 16-bit audio-buffer address and the data-buffer address.
- R3: Opcode 0x10 followed by three bytes loads `in_mask`. Opcode 0x20 followed by three bytes loads `save_mask`.
- R4: Opcode 0x3m sets `mapper_mode` to m only when m is 0, 1, 2, 6 or 7. Any other m leaves the mode unchanged.
- R5: After opcode 0x8p, each later byte slot returns the RAM byte at the current RAM address. The first slot returns the byte at the loaded address. When p bit 3 is 1, the address advances by one for each byte slot completed after the opcode.
- R6: After opcode 0x9p, each later byte is written to target p[1:0] (0 = RAM, 1 = audio buffer, 2 = data buffer) at that target's address. The address then advances when p bit 3 is 1. Target 3 writes nothing.
- R7: Opcode 0xE0 takes a set byte and then a clear byte. When the clear byte arrives, the status becomes (status AND NOT clear) OR set, so a bit named in both masks ends up 1.
- R8: Opcode 0xED loads `feature_en` from the next byte. Later bytes in the same frame (trailing dummy bytes) are ignored.
- R9: Opcode 0xF0 returns 0xA5 in the next slot. Opcode 0xF1 returns {dma_busy, 7'b0} and then the status register. Opcode 0xFF returns each received byte in the following slot. Slots with no defined readback return 0x00.
- R10: The opcode slot always returns 0x00. Undefined opcodes (for example 0x4x to 0x7x, 0xA0 to 0xDF, and 0xE1 to 0xEC) change no register and return 0x00 in every slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| dma_busy | input | 1 | DMA engine busy flag for the status word |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| mem_tgt | output | 2 | Target of the memory request |
| mem_addr | output | 24 | Address of the memory request |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, one cycle |
| mem_re | output | 1 | Read strobe, one cycle |
| ram_addr | output | 24 | Current RAM access address |
| audio_addr | output | 16 | Current audio-buffer address |
| data_addr | output | 16 | Current data-buffer address |
| in_mask | output | 24 | Input address mask |
| save_mask | output | 24 | Save-RAM address mask |
| mapper_mode | output | 4 | Selected mapper mode |
| feature_en | output | 8 | Feature-enable bits |
| status_reg | output | 8 | Status register |

## Verification
The assertions assume that the SPI clock's half period is several times longer than the block clock period. They also assume that `spi_cs_n` changes only while `spi_sck` is low and well away from any clock edge, so that a completed byte is always seen inside its frame. They further assume that `mem_rdata` holds the addressed byte on the cycle after `mem_re`. The bench meets these assumptions by holding every SPI level for eight block clocks and by waiting ten clocks around each chip-select edge. Its memory model answers with exactly one cycle of latency.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        TGT_RAM   = 2'd0,
        TGT_AUDIO = 2'd1,
        TGT_DATA  = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    localparam logic [3:0] CLS_ADDR   = 4'h0;
    localparam logic [3:0] CLS_MAPPER = 4'h3;
    localparam logic [3:0] CLS_READ   = 4'h8;
    localparam logic [3:0] CLS_WRITE  = 4'h9;
    localparam logic [3:0] CLS_CTRL   = 4'hE;
    localparam logic [3:0] CLS_QUERY  = 4'hF;

    localparam logic [7:0] OP_IN_MASK   = 8'h10;
    localparam logic [7:0] OP_SAVE_MASK = 8'h20;
    localparam logic [7:0] OP_STATUS_SR = 8'hE0;
    localparam logic [7:0] OP_FEATURES  = 8'hED;
    localparam logic [7:0] OP_TOKEN     = 8'hF0;
    localparam logic [7:0] OP_STATUS_RD = 8'hF1;
    localparam logic [7:0] OP_ECHO      = 8'hFF;

    localparam logic [7:0] TEST_TOKEN = 8'hA5;

    function automatic logic mapper_ok(input logic [3:0] m);
        return (m == 4'd0) || (m == 4'd1) || (m == 4'd2) || (m == 4'd6) || (m == 4'd7);
    endfunction

endpackage

// File: rtl/spi_byte_link.sv
module spi_byte_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       cs_act,
    output logic       byte_valid,
    output logic [7:0] rx_byte
);

    typedef struct packed {
        logic [2:0] sck_s;
        logic [1:0] cs_s;
        logic [1:0] mosi_s;
        logic [2:0] bit_cnt;
        logic [7:0] rx_sh;
        logic [7:0] tx_sh;
        logic       valid;
        logic [7:0] rx_out;
    } link_t;

    link_t q, d;

    logic rise, fall, in_frame;

    always_comb begin
        d        = q;
        d.sck_s  = {q.sck_s[1:0], sck};
        d.cs_s   = {q.cs_s[0], cs_n};
        d.mosi_s = {q.mosi_s[0], mosi};
        d.valid  = 1'b0;
        rise     = q.sck_s[1] & ~q.sck_s[2];
        fall     = ~q.sck_s[1] & q.sck_s[2];
        in_frame = ~q.cs_s[1];
        if (!in_frame) begin
            d.bit_cnt = '0;
            d.tx_sh   = '0;
        end else begin
            if (rise) begin
                d.rx_sh   = {q.rx_sh[6:0], q.mosi_s[1]};
                d.bit_cnt = q.bit_cnt + 3'd1;
                if (q.bit_cnt == 3'd7) begin
                    d.valid  = 1'b1;
                    d.rx_out = {q.rx_sh[6:0], q.mosi_s[1]};
                end
            end
            if (fall) begin
                if (q.bit_cnt == 3'd0) d.tx_sh = tx_byte;
                else                   d.tx_sh = {q.tx_sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_s <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign miso       = q.tx_sh[7];
    assign cs_act     = ~q.cs_s[1];
    assign byte_valid = q.valid;
    assign rx_byte    = q.rx_out;

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int AUX_BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_act,
    input  logic                    byte_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    dma_busy,
    input  logic [7:0]              mem_rdata,
    output logic [7:0]              tx_byte,
    output logic [1:0]              mem_tgt,
    output logic [8*ADDR_BYTES-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    mem_we,
    output logic                    mem_re,
    output logic [8*ADDR_BYTES-1:0] ram_addr,
    output logic [8*AUX_BYTES-1:0]  audio_addr,
    output logic [8*AUX_BYTES-1:0]  data_addr,
    output logic [8*ADDR_BYTES-1:0] in_mask,
    output logic [8*ADDR_BYTES-1:0] save_mask,
    output logic [3:0]              mapper_mode,
    output logic [7:0]              feature_en,
    output logic [7:0]              status_reg
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int AUX_W  = 8 * AUX_BYTES;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_AUX  = CNT_W'(AUX_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        op;
        logic [ADDR_W-1:0] acc;
        logic [7:0]        setm;
        logic [7:0]        tx;
        logic              rd_wait;
        logic [ADDR_W-1:0] ram_a;
        logic [AUX_W-1:0]  aud_a;
        logic [AUX_W-1:0]  dat_a;
        logic [ADDR_W-1:0] in_m;
        logic [ADDR_W-1:0] sv_m;
        logic [3:0]        mapper;
        logic [7:0]        feat;
        logic [7:0]        stat;
        logic              we;
        logic              re;
        tgt_e              tgt;
        logic [ADDR_W-1:0] maddr;
        logic [7:0]        wdata;
    } regs_t;

    regs_t q, d;
    logic [ADDR_W-1:0] acc_n;
    tgt_e              wtgt;

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.re      = 1'b0;
        d.rd_wait = q.re;
        acc_n     = {q.acc[ADDR_W-9:0], rx_byte};
        wtgt      = tgt_e'(q.op[1:0]);
        if (q.rd_wait) d.tx = mem_rdata;
        if (!cs_act) begin
            d.cnt = '0;
            d.op  = '0;
            d.acc = '0;
            d.tx  = '0;
        end else if (byte_valid) begin
            if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
            d.tx = '0;
            if (q.cnt == '0) begin
                d.op = rx_byte;
                if (rx_byte[7:4] == CLS_MAPPER && mapper_ok(rx_byte[3:0]))
                    d.mapper = rx_byte[3:0];
                if (rx_byte[7:4] == CLS_READ) begin
                    d.re    = 1'b1;
                    d.tgt   = TGT_RAM;
                    d.maddr = q.ram_a;
                end
                if (rx_byte == OP_TOKEN)     d.tx = TEST_TOKEN;
                if (rx_byte == OP_STATUS_RD) d.tx = {dma_busy, 7'b0};
                if (rx_byte == OP_ECHO)      d.tx = rx_byte;
            end else begin
                d.acc = acc_n;
                case (q.op[7:4])
                    CLS_ADDR: begin
                        if (q.op[3:2] == 2'b00) begin
                            if (wtgt == TGT_RAM && q.cnt == CNT_ADDR)
                                d.ram_a = acc_n;
                            if (wtgt == TGT_AUDIO && q.cnt == CNT_AUX)
                                d.aud_a = acc_n[AUX_W-1:0];
                            if (wtgt == TGT_DATA && q.cnt == CNT_AUX)
                                d.dat_a = acc_n[AUX_W-1:0];
                        end
                    end
                    4'h1: if (q.op == OP_IN_MASK && q.cnt == CNT_ADDR) d.in_m = acc_n;
                    4'h2: if (q.op == OP_SAVE_MASK && q.cnt == CNT_ADDR) d.sv_m = acc_n;
                    CLS_READ: begin
                        if (q.op[3]) d.ram_a = q.ram_a + 1'b1;
                        d.re    = 1'b1;
                        d.tgt   = TGT_RAM;
                        d.maddr = q.op[3] ? q.ram_a + 1'b1 : q.ram_a;
                    end
                    CLS_WRITE: begin
                        if (wtgt != TGT_NONE) begin
                            d.we    = 1'b1;
                            d.tgt   = wtgt;
                            d.wdata = rx_byte;
                            case (wtgt)
                                TGT_RAM:   d.maddr = q.ram_a;
                                TGT_AUDIO: d.maddr = ADDR_W'(q.aud_a);
                                default:   d.maddr = ADDR_W'(q.dat_a);
                            endcase
                            if (q.op[3]) begin
                                case (wtgt)
                                    TGT_RAM:   d.ram_a = q.ram_a + 1'b1;
                                    TGT_AUDIO: d.aud_a = q.aud_a + 1'b1;
                                    default:   d.dat_a = q.dat_a + 1'b1;
                                endcase
                            end
                        end
                    end
                    CLS_CTRL: begin
                        if (q.op == OP_STATUS_SR && q.cnt == CNT_W'(1)) d.setm = rx_byte;
                        if (q.op == OP_STATUS_SR && q.cnt == CNT_W'(2))
                            d.stat = (q.stat & ~rx_byte) | q.setm;
                        if (q.op == OP_FEATURES && q.cnt == CNT_W'(1)) d.feat = rx_byte;
                    end
                    CLS_QUERY: begin
                        if (q.op == OP_STATUS_RD && q.cnt == CNT_W'(1)) d.tx = q.stat;
                        if (q.op == OP_ECHO) d.tx = rx_byte;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.tgt <= TGT_RAM;
        end else begin
            q <= d;
        end
    end

    assign tx_byte     = q.tx;
    assign mem_tgt     = q.tgt;
    assign mem_addr    = q.maddr;
    assign mem_wdata   = q.wdata;
    assign mem_we      = q.we;
    assign mem_re      = q.re;
    assign ram_addr    = q.ram_a;
    assign audio_addr  = q.aud_a;
    assign data_addr   = q.dat_a;
    assign in_mask     = q.in_m;
    assign save_mask   = q.sv_m;
    assign mapper_mode = q.mapper;
    assign feature_en  = q.feat;
    assign status_reg  = q.stat;

    // R1: a completed byte from the link always lies inside a frame
    a_r1_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> cs_act);

    // R1: leaving the frame drops the command context
    a_r1_clear_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (q.cnt == '0 && q.op == '0));

    // R4: only defined mapper numbers are ever held
    a_r4_mapper_defined: assert property (@(posedge clk) disable iff (!rst_n)
        mapper_ok(q.mapper));

    // R7: status moves only after a received byte
    a_r7_status_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.stat) |-> $past(byte_valid));

    // R8: feature byte moves only after a received byte
    a_r8_feat_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.feat) |-> $past(byte_valid));

    // R6: never read and write in one cycle, and never write to target 3
    a_r6_no_we_re: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    a_r6_we_target: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_tgt != TGT_NONE);

    // R5: reads address main RAM only
    a_r5_read_ram: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_tgt == TGT_RAM);

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int AUX_BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    input  logic                    dma_busy,
    input  logic [7:0]              mem_rdata,
    output logic [1:0]              mem_tgt,
    output logic [8*ADDR_BYTES-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    mem_we,
    output logic                    mem_re,
    output logic [8*ADDR_BYTES-1:0] ram_addr,
    output logic [8*AUX_BYTES-1:0]  audio_addr,
    output logic [8*AUX_BYTES-1:0]  data_addr,
    output logic [8*ADDR_BYTES-1:0] in_mask,
    output logic [8*ADDR_BYTES-1:0] save_mask,
    output logic [3:0]              mapper_mode,
    output logic [7:0]              feature_en,
    output logic [7:0]              status_reg
);

    logic       cs_act, byte_valid;
    logic [7:0] rx_byte, tx_byte;

    spi_byte_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (spi_sck),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .tx_byte    (tx_byte),
        .miso       (spi_miso),
        .cs_act     (cs_act),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte)
    );

    spi_cmd_regs #(
        .ADDR_BYTES (ADDR_BYTES),
        .AUX_BYTES  (AUX_BYTES)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act      (cs_act),
        .byte_valid  (byte_valid),
        .rx_byte     (rx_byte),
        .dma_busy    (dma_busy),
        .mem_rdata   (mem_rdata),
        .tx_byte     (tx_byte),
        .mem_tgt     (mem_tgt),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .ram_addr    (ram_addr),
        .audio_addr  (audio_addr),
        .data_addr   (data_addr),
        .in_mask     (in_mask),
        .save_mask   (save_mask),
        .mapper_mode (mapper_mode),
        .feature_en  (feature_en),
        .status_reg  (status_reg)
    );

endmodule

// File: tb/test_spi_cmd_decoder.sv
module test_spi_cmd_decoder;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
    logic miso;
    logic [7:0]  rdata = '0;
    logic [1:0]  tgt;
    logic [23:0] maddr, r_addr, i_mask, s_mask;
    logic [15:0] a_addr, d_addr;
    logic [7:0]  wdata, feat, stat;
    logic [3:0]  mapper;
    logic        we, re;

    always #2 clk = ~clk;

    spi_cmd_decoder i_spi_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .dma_busy(busy), .mem_rdata(rdata), .mem_tgt(tgt),
        .mem_addr(maddr), .mem_wdata(wdata), .mem_we(we), .mem_re(re),
        .ram_addr(r_addr), .audio_addr(a_addr), .data_addr(d_addr),
        .in_mask(i_mask), .save_mask(s_mask), .mapper_mode(mapper),
        .feature_en(feat), .status_reg(stat)
    );

    int checks = 0, errors = 0, reg_prints = 0;
    bit idle = 1'b0, done = 1'b0;

    logic [7:0]  ram [256];
    logic [33:0] exp_w[$], got_w[$];

    logic [23:0] m_ram = '0, m_in = '0, m_sv = '0;
    logic [15:0] m_aud = '0, m_dat = '0;
    logic [3:0]  m_map = '0;
    logic [7:0]  m_feat = '0, m_stat = '0;

    initial for (int i = 0; i < 256; i++) ram[i] = 8'(i) ^ 8'h5A;

    always @(posedge clk) begin
        if (re) rdata <= ram[maddr[7:0]];
        if (we) begin
            got_w.push_back({tgt, maddr, wdata});
            if (tgt == 2'd0) ram[maddr[7:0]] <= wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference register state compared on every idle clock (R2 R3 R4 R7 R8)
    always @(negedge clk) begin
        if (idle && !done) begin
            logic [135:0] act, exp;
            act = {r_addr, a_addr, d_addr, i_mask, s_mask, mapper, feat, stat, 4'h0};
            exp = {m_ram, m_aud, m_dat, m_in, m_sv, m_map, m_feat, m_stat, 4'h0};
            checks++;
            if (act != exp) begin
                errors++;
                if (reg_prints < 10) begin
                    reg_prints++;
                    $display("FAIL R2/R3/R4/R7/R8 register state: actual %h expected %h", act, exp);
                end
            end
        end
    end

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk) mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic transact(input logic [7:0] bytes[$], input string req);
        logic [7:0] expm, op, setm, rx;
        logic [23:0] acc, wa;
        idle = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (10) @(negedge clk);
        expm = 8'h00; op = 8'h00; setm = 8'h00; acc = '0;
        for (int i = 0; i < bytes.size(); i++) begin
            logic [7:0] b;
            b = bytes[i];
            xfer(b, rx);
            chk(rx == expm, $sformatf("%s MISO slot %0d", req, i), {24'h0, rx}, {24'h0, expm});
            expm = 8'h00;
            if (i == 0) begin
                op = b;
                if (b[7:4] == 4'h3 && (b[3:0] inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd7})) m_map = b[3:0];
                if (b[7:4] == 4'h8) expm = ram[m_ram[7:0]];
                if (b == 8'hF0) expm = 8'hA5;
                if (b == 8'hF1) expm = {busy, 7'b0};
                if (b == 8'hFF) expm = 8'hFF;
            end else begin
                acc = {acc[15:0], b};
                if (op == 8'h00 && i == 3) m_ram = acc;
                if (op == 8'h01 && i == 2) m_aud = acc[15:0];
                if (op == 8'h02 && i == 2) m_dat = acc[15:0];
                if (op == 8'h10 && i == 3) m_in = acc;
                if (op == 8'h20 && i == 3) m_sv = acc;
                if (op[7:4] == 4'h8) begin
                    if (op[3]) m_ram = m_ram + 24'd1;
                    expm = ram[m_ram[7:0]];
                end
                if (op[7:4] == 4'h9 && op[1:0] != 2'd3) begin
                    wa = (op[1:0] == 2'd0) ? m_ram : (op[1:0] == 2'd1) ? {8'h0, m_aud} : {8'h0, m_dat};
                    exp_w.push_back({op[1:0], wa, b});
                    if (op[3]) begin
                        if (op[1:0] == 2'd0) m_ram = m_ram + 24'd1;
                        else if (op[1:0] == 2'd1) m_aud = m_aud + 16'd1;
                        else m_dat = m_dat + 16'd1;
                    end
                end
                if (op == 8'hE0 && i == 1) setm = b;
                if (op == 8'hE0 && i == 2) m_stat = (m_stat & ~b) | setm;
                if (op == 8'hED && i == 1) m_feat = b;
                if (op == 8'hF1 && i == 1) expm = m_stat;
                if (op == 8'hFF) expm = b;
            end
        end
        repeat (10) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(got_w.size() == exp_w.size(), {req, " write count"}, got_w.size(), exp_w.size());
        while (exp_w.size() > 0 && got_w.size() > 0) begin
            logic [33:0] e, g;
            e = exp_w.pop_front();
            g = got_w.pop_front();
            chk(g == e, {req, " write"}, {30'h0, g[33:32]} ^ g[31:0], {30'h0, e[33:32]} ^ e[31:0]);
        end
        exp_w.delete();
        got_w.delete();
        idle = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(miso == 1'b0 && stat == 8'h00 && mapper == 4'h0, "R1 reset", {23'h0, miso, stat}, 32'h0);
        idle = 1'b1;
        repeat (4) @(negedge clk);

        transact('{8'h00, 8'h12, 8'h34, 8'h56}, "R2");
        transact('{8'h01, 8'hAB, 8'hCD}, "R2");
        transact('{8'h02, 8'h11, 8'h22, 8'h00}, "R2");
        transact('{8'h10, 8'hF0, 8'h0F, 8'h55}, "R3");
        transact('{8'h20, 8'h00, 8'h1F, 8'hFF}, "R3");
        transact('{8'h37}, "R4");
        transact('{8'h34}, "R4");
        transact('{8'h3F}, "R4");
        transact('{8'h31}, "R4");
        // R6 writes into RAM with increment, then R5 reads back
        transact('{8'h00, 8'h00, 8'h00, 8'h10}, "R2");
        transact('{8'h98, 8'hC1, 8'hC2, 8'hC3, 8'hC4}, "R6");
        transact('{8'h00, 8'h00, 8'h00, 8'h10}, "R2");
        transact('{8'h88, 8'h00, 8'h00, 8'h00, 8'h00}, "R5");
        transact('{8'h80, 8'h00, 8'h00, 8'h00}, "R5");
        transact('{8'h90, 8'h77, 8'h78}, "R6");
        transact('{8'h99, 8'h01, 8'h02}, "R6");
        transact('{8'h9A, 8'h0A, 8'h0B, 8'h0C}, "R6");
        transact('{8'h93, 8'hEE, 8'hEE}, "R6");
        transact('{8'hE0, 8'hF0, 8'h00, 8'h00}, "R7");
        transact('{8'hE0, 8'h0F, 8'h30, 8'h00}, "R7");
        transact('{8'hE0, 8'h81, 8'h81, 8'h00}, "R7");
        // R1 aborted commands
        transact('{8'hE0, 8'hFF}, "R1");
        transact('{8'h00, 8'hAA, 8'hBB}, "R1");
        transact('{8'h10, 8'h01}, "R1");
        transact('{8'hED, 8'h5C, 8'h00, 8'h00}, "R8");
        transact('{8'hF0, 8'h00, 8'h00}, "R9");
        busy = 1'b1;
        transact('{8'hF1, 8'h00, 8'h00, 8'h00}, "R9");
        busy = 1'b0;
        transact('{8'hF1, 8'h00, 8'h00}, "R9");
        transact('{8'hFF, 8'h11, 8'h22, 8'h33}, "R9");
        // R10 undefined opcodes
        transact('{8'h70, 8'h12, 8'h34, 8'h56}, "R10");
        transact('{8'hE9, 8'h01, 8'h02, 8'h03}, "R10");
        transact('{8'h03, 8'h99, 8'h88, 8'h77}, "R10");
        transact('{8'h11, 8'h99, 8'h88, 8'h77}, "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule